// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Threshold Flags

This block is a first-in first-out buffer for 9-bit words whose write side and read side each run on their own clock. The two clocks may be one shared clock or fully unrelated. Each side keeps a binary pointer and a Gray-coded copy of it. The Gray copy crosses to the other side through a two-stage synchronizer. Each side then turns the synchronized Gray value back into binary and computes its fill level.

The read side reports an active-low empty flag and an active-low almost-empty flag. The write side reports an active-low full flag and an active-low almost-full flag. The two fixed flags never depend on the programmed thresholds. Writes need two enables, one active-low and one active-high. Reads need two active-low enables. The active-high write enable also serves as a load strobe for the two threshold registers. Which role it takes is set by its level while reset is held.

The read data sits in a register on the read clock. An active-low output enable gates that register onto the output port and raises a valid bit.

Top module: `dual_clk_fifo_pf`

## Requirements
- R1: The depth is the parameter DEPTH (256 to 4096, a power of two). full_n goes low exactly when DEPTH words are held, and all DEPTH words are returned in order.
- R2: A word from din is stored on a rising wclk edge only when wen1_n is 0 and wen2_ld is 1. Any other enable combination stores nothing.
- R3: A word is read on a rising rclk edge only when ren1_n and ren2_n are both 0. The read word appears in the output register after that edge, and the register holds its value in every other cycle.
- R4: A write while full_n is 0, or a read while empty_n is 0, is ignored and leaves both pointers unchanged. A word offered while the FIFO is full never comes out.
- R5: empty_n is low when the read side sees zero words, and full_n is low when the write side sees DEPTH words. With one shared clock, a write on edge k reaches the read-side flags after edge k+3, and a read on edge k reaches the write-side flags after edge k+3. A side's own pointer change takes effect at once.
- R6: pae_n is low when the read-side word count is less than or equal to the almost-empty offset. paf_n is low when the write-side word count is greater than or equal to DEPTH minus the almost-full offset.
- R7: The level of wen2_ld while rst_n is low selects its role. 1 selects plain write enable. 0 selects load mode, in which wen1_n=0 with wen2_ld=0 loads an offset and stores nothing in the array, while wen1_n=0 with wen2_ld=1 still writes a word.
- R8: Successive loads go to the almost-empty offset first, then to the almost-full offset, then back to the almost-empty offset. The loaded value is din zero-extended or truncated to log2(DEPTH) bits. The offsets change only on a load.
- R9: When oe_n is 0, dout equals the output register and dout_vld is 1. When oe_n is 1, dout is all zeros and dout_vld is 0.
- R10: Reset is synchronous and active-low and is seen on each clock. It clears both pointers and the output register, drives empty_n=0, pae_n=0, full_n=1 and paf_n=1, and sets both offsets to 7.
- R11: With unrelated clocks, every accepted word is read back once, in write order. Each Gray pointer changes by at most one bit per edge of its own clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-side clock |
| rclk | input | 1 | Read-side clock |
| rst_n | input | 1 | Synchronous active-low reset, seen on both clocks |
| din | input | 9 | Write data, or offset value in load mode |
| wen1_n | input | 1 | Active-low write enable |
| wen2_ld | input | 1 | Active-high write enable, or active-low load strobe in load mode |
| ren1_n | input | 1 | Active-low read enable, first |
| ren2_n | input | 1 | Active-low read enable, second |
| oe_n | input | 1 | Active-low output enable |
| dout | output | 9 | Read data, zero while disabled |
| dout_vld | output | 1 | High while dout carries the read register |
| empty_n | output | 1 | Active-low empty flag, read side |
| full_n | output | 1 | Active-low full flag, write side |
| pae_n | output | 1 | Active-low almost-empty flag, read side |
| paf_n | output | 1 | Active-low almost-full flag, write side |

## Verification
The checker watches several properties on every edge of the owning clock:
- a full or empty FIFO leaves its pointer still;
- each Gray pointer moves by one bit at most;
- full implies almost-full, and empty implies almost-empty;
- the read register and the offset registers hold unless their strobes allow a change;
- the flags come out of reset at their reset values.

Some behaviour depends on history that a simple property cannot hold, and only the bench's scenarios show it. This covers the three-edge flag latency across the synchronizers, the exact word order and values, the wrap-around of the load sequence, and integrity under unrelated clocks. The bench shows these with a shared-clock reference model and with a free-running stream on two clocks.

// File: rtl/pf_pkg.sv
// Shared definitions for the dual-clock programmable-flag FIFO.
// Assumes: nothing beyond IEEE 1800-2017 packages.
package pf_pkg;
    localparam int DATA_W = 9;

    // Role of the shared active-high write enable, latched during reset
    typedef enum logic {PIN_WEN2 = 1'b0, PIN_LOAD = 1'b1} pin_mode_e;

    // Which offset register the next load targets
    typedef enum logic {OFS_AE = 1'b0, OFS_AF = 1'b1} ofs_sel_e;
endpackage

// File: rtl/pf_sync2.sv
// Two-stage synchronizer for a Gray-coded pointer entering a clock domain.
// Assumes: the input changes by at most one bit per source-clock edge.
module pf_sync2 #(
    parameter int W = 9
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    // Capture stage then settle stage, both cleared by reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/pf_mem.sv
// Storage array, written on the write clock and read into a register on the
// read clock. Assumes: the write and read addresses never collide while the
// read register loads, which the flag logic guarantees.
module pf_mem #(
    parameter int AW = 8,
    parameter int DW = 9
) (
    input  logic          wclk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic          rclk,
    input  logic          rst_n,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] q
);
    localparam int WORDS = 1 << AW;

    logic [DW-1:0] cells [WORDS];

    // Store one word per accepted write
    always_ff @(posedge wclk) begin
        if (we) cells[waddr] <= wdata;
    end

    // Load the read register on an accepted read, otherwise hold it
    always_ff @(posedge rclk) begin
        if (!rst_n)  q <= '0;
        else if (re) q <= cells[raddr];
    end
endmodule

// File: rtl/pf_wr_ctl.sv
// Write-side control. Keeps the write pointer and the full and almost-full
// flags, latches the role of the shared enable during reset, and loads the
// two offset registers in almost-empty, almost-full order.
// Assumes: rq2_gray is the read Gray pointer already synchronized to wclk.
module pf_wr_ctl
    import pf_pkg::*;
#(
    parameter int AW      = 8,
    parameter int DW      = 9,
    parameter int OFS_RST = 7
) (
    input  logic          wclk,
    input  logic          rst_n,
    input  logic [DW-1:0] din,
    input  logic          wen1_n,
    input  logic          wen2_ld,
    input  logic [AW:0]   rq2_gray,
    output logic          wr_fire,
    output logic [AW-1:0] waddr,
    output logic [AW:0]   wgray,
    output logic          full_n,
    output logic          paf_n,
    output logic [AW-1:0] ae_ofs,
    output logic [AW-1:0] af_ofs
);
    localparam int            PW  = AW + 1;
    localparam logic [PW-1:0] CAP = PW'(1 << AW);

    pin_mode_e     mode;
    ofs_sel_e      sel;
    logic [PW-1:0] wbin, wbin_nx, rbin_s, wcnt;
    logic          ld_fire;
    logic [AW-1:0] ld_val;

    // Offset value taken from the data bus, sized to the pointer width
    generate
        if (AW <= DW) begin : g_trunc
            assign ld_val = din[AW-1:0];
        end else begin : g_zext
            assign ld_val = {{(AW - DW){1'b0}}, din};
        end
    endgenerate

    // Qualify writes and loads from the enable pair and the latched role
    always_comb begin
        wr_fire = !wen1_n && wen2_ld && full_n;
        ld_fire = (mode == PIN_LOAD) && !wen1_n && !wen2_ld;
    end

    // Decode the synchronized read pointer and compute the write-side count
    always_comb begin
        for (int i = 0; i < PW; i++) rbin_s[i] = ^(rq2_gray >> i);
        wbin_nx = wbin + PW'(wr_fire);
        wcnt    = wbin_nx - rbin_s;
    end

    // Pointer, Gray copy and registered flags
    always_ff @(posedge wclk) begin
        if (!rst_n) begin
            mode   <= wen2_ld ? PIN_WEN2 : PIN_LOAD;
            wbin   <= '0;
            wgray  <= '0;
            full_n <= 1'b1;
            paf_n  <= 1'b1;
        end else begin
            wbin   <= wbin_nx;
            wgray  <= wbin_nx ^ (wbin_nx >> 1);
            full_n <= (wcnt != CAP);
            paf_n  <= !(wcnt >= CAP - PW'(af_ofs));
        end
    end

    // Offset registers, loaded in turn by the shared strobe
    always_ff @(posedge wclk) begin
        if (!rst_n) begin
            ae_ofs <= AW'(OFS_RST);
            af_ofs <= AW'(OFS_RST);
            sel    <= OFS_AE;
        end else if (ld_fire) begin
            if (sel == OFS_AE) begin
                ae_ofs <= ld_val;
                sel    <= OFS_AF;
            end else begin
                af_ofs <= ld_val;
                sel    <= OFS_AE;
            end
        end
    end

    assign waddr = wbin[AW-1:0];
endmodule

// File: rtl/pf_rd_ctl.sv
// Read-side control. Keeps the read pointer and the empty and almost-empty
// flags. Assumes: wq2_gray is the write Gray pointer synchronized to rclk,
// and ae_ofs is static while the read side uses it.
module pf_rd_ctl #(
    parameter int AW = 8
) (
    input  logic          rclk,
    input  logic          rst_n,
    input  logic          ren1_n,
    input  logic          ren2_n,
    input  logic [AW:0]   wq2_gray,
    input  logic [AW-1:0] ae_ofs,
    output logic          rd_fire,
    output logic [AW-1:0] raddr,
    output logic [AW:0]   rgray,
    output logic          empty_n,
    output logic          pae_n
);
    localparam int PW = AW + 1;

    logic [PW-1:0] rbin, rbin_nx, wbin_s, rcnt;

    // Qualify the read and compute the read-side count
    always_comb begin
        rd_fire = !ren1_n && !ren2_n && empty_n;
        for (int i = 0; i < PW; i++) wbin_s[i] = ^(wq2_gray >> i);
        rbin_nx = rbin + PW'(rd_fire);
        rcnt    = wbin_s - rbin_nx;
    end

    // Pointer, Gray copy and registered flags
    always_ff @(posedge rclk) begin
        if (!rst_n) begin
            rbin    <= '0;
            rgray   <= '0;
            empty_n <= 1'b0;
            pae_n   <= 1'b0;
        end else begin
            rbin    <= rbin_nx;
            rgray   <= rbin_nx ^ (rbin_nx >> 1);
            empty_n <= (rcnt != '0);
            pae_n   <= !(rcnt <= PW'(ae_ofs));
        end
    end

    assign raddr = rbin[AW-1:0];
endmodule

// File: rtl/dual_clk_fifo_pf.sv
// Top of the dual-clock FIFO with programmable flags. Wires the write and
// read control, the two pointer synchronizers and the array, and gates the
// read register onto the output. Assumes: DEPTH is a power of two, 256..4096.
module dual_clk_fifo_pf #(
    parameter int DEPTH       = 256,
    parameter int OFS_DEFAULT = 7
) (
    input  logic                      wclk,
    input  logic                      rclk,
    input  logic                      rst_n,
    input  logic [pf_pkg::DATA_W-1:0] din,
    input  logic                      wen1_n,
    input  logic                      wen2_ld,
    input  logic                      ren1_n,
    input  logic                      ren2_n,
    input  logic                      oe_n,
    output logic [pf_pkg::DATA_W-1:0] dout,
    output logic                      dout_vld,
    output logic                      empty_n,
    output logic                      full_n,
    output logic                      pae_n,
    output logic                      paf_n
);
    localparam int DW = pf_pkg::DATA_W;
    localparam int AW = $clog2(DEPTH);

    logic          wr_fire, rd_fire;
    logic [AW-1:0] waddr, raddr, ae_ofs, af_ofs;
    logic [AW:0]   wgray, rgray, wq2_gray, rq2_gray;
    logic [DW-1:0] q_raw;

    pf_wr_ctl #(.AW(AW), .DW(DW), .OFS_RST(OFS_DEFAULT)) u_wr (
        .wclk(wclk), .rst_n(rst_n), .din(din), .wen1_n(wen1_n),
        .wen2_ld(wen2_ld), .rq2_gray(rq2_gray), .wr_fire(wr_fire),
        .waddr(waddr), .wgray(wgray), .full_n(full_n), .paf_n(paf_n),
        .ae_ofs(ae_ofs), .af_ofs(af_ofs)
    );

    pf_rd_ctl #(.AW(AW)) u_rd (
        .rclk(rclk), .rst_n(rst_n), .ren1_n(ren1_n), .ren2_n(ren2_n),
        .wq2_gray(wq2_gray), .ae_ofs(ae_ofs), .rd_fire(rd_fire),
        .raddr(raddr), .rgray(rgray), .empty_n(empty_n), .pae_n(pae_n)
    );

    pf_sync2 #(.W(AW + 1)) u_w2r (
        .clk(rclk), .rst_n(rst_n), .d(wgray), .q(wq2_gray)
    );

    pf_sync2 #(.W(AW + 1)) u_r2w (
        .clk(wclk), .rst_n(rst_n), .d(rgray), .q(rq2_gray)
    );

    pf_mem #(.AW(AW), .DW(DW)) u_mem (
        .wclk(wclk), .we(wr_fire), .waddr(waddr), .wdata(din),
        .rclk(rclk), .rst_n(rst_n), .re(rd_fire), .raddr(raddr), .q(q_raw)
    );

    // Output qualifier: zero data and no valid while disabled
    assign dout     = oe_n ? '0 : q_raw;
    assign dout_vld = !oe_n;
endmodule

// File: rtl/pf_fifo_checker.sv
// Protocol checker for dual_clk_fifo_pf, attached by bind below.
// Assumes: rst_n is held low across at least one edge of each clock.
module pf_fifo_checker #(
    parameter int AW = 8,
    parameter int DW = 9
) (
    input logic          wclk,
    input logic          rclk,
    input logic          rst_n,
    input logic          wen1_n,
    input logic          wen2_ld,
    input logic          ren1_n,
    input logic          ren2_n,
    input logic          full_n,
    input logic          empty_n,
    input logic          pae_n,
    input logic          paf_n,
    input logic [AW:0]   wgray,
    input logic [AW:0]   rgray,
    input logic [DW-1:0] q_raw,
    input logic [AW-1:0] ae_ofs,
    input logic [AW-1:0] af_ofs
);
    AST_NO_OVERFLOW: assert property (@(posedge wclk) disable iff (!rst_n)
        !full_n |=> $stable(wgray)); // R4
    AST_NO_UNDERFLOW: assert property (@(posedge rclk) disable iff (!rst_n)
        !empty_n |=> $stable(rgray)); // R4
    AST_WPTR_GRAY_STEP: assert property (@(posedge wclk) disable iff (!rst_n)
        $countones(wgray ^ $past(wgray)) <= 1); // R11
    AST_RPTR_GRAY_STEP: assert property (@(posedge rclk) disable iff (!rst_n)
        $countones(rgray ^ $past(rgray)) <= 1); // R11
    AST_FULL_IMPLIES_AF: assert property (@(posedge wclk) disable iff (!rst_n)
        !full_n |-> !paf_n); // R6
    AST_EMPTY_IMPLIES_AE: assert property (@(posedge rclk) disable iff (!rst_n)
        !empty_n |-> !pae_n); // R6
    AST_RDATA_HOLD: assert property (@(posedge rclk) disable iff (!rst_n)
        (ren1_n || ren2_n) |=> $stable(q_raw)); // R3
    AST_OFS_HOLD: assert property (@(posedge wclk) disable iff (!rst_n)
        (wen1_n || wen2_ld) |=> ($stable(ae_ofs) && $stable(af_ofs))); // R8
    AST_RESET_WFLAGS: assert property (@(posedge wclk)
        !rst_n |=> (full_n && paf_n)); // R10
    AST_RESET_RFLAGS: assert property (@(posedge rclk)
        !rst_n |=> (!empty_n && !pae_n && (q_raw == '0))); // R10
endmodule

bind dual_clk_fifo_pf pf_fifo_checker #(.AW(AW), .DW(DW)) u_chk (
    .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .wen1_n(wen1_n),
    .wen2_ld(wen2_ld), .ren1_n(ren1_n), .ren2_n(ren2_n), .full_n(full_n),
    .empty_n(empty_n), .pae_n(pae_n), .paf_n(paf_n), .wgray(wgray),
    .rgray(rgray), .q_raw(q_raw), .ae_ofs(ae_ofs), .af_ofs(af_ofs)
);

// File: tb/sim_dual_clk_fifo_pf.sv
`timescale 1ns/1ps
// Bench: shared-clock reference model compared every cycle, then a
// two-clock streaming phase checked for order and value.
module sim_dual_clk_fifo_pf;
    localparam int DEPTH = 256;

    logic       clk = 1'b0, rclk_a = 1'b0, async_ph = 1'b0;
    logic       rclk;
    logic       rst_n, wen1_n, wen2_ld, ren1_n, ren2_n, oe_n;
    logic [8:0] din;
    logic [8:0] dout;
    logic       dout_vld, empty_n, full_n, pae_n, paf_n;

    always #2.5 clk = ~clk;
    always #3.5 rclk_a = ~rclk_a;
    assign rclk = async_ph ? rclk_a : clk;

    int n_cmp = 0, n_bad = 0;
    bit done = 1'b0;

    dual_clk_fifo_pf #(.DEPTH(DEPTH)) u0 (
        .wclk(clk), .rclk(rclk), .rst_n(rst_n), .din(din), .wen1_n(wen1_n),
        .wen2_ld(wen2_ld), .ren1_n(ren1_n), .ren2_n(ren2_n), .oe_n(oe_n),
        .dout(dout), .dout_vld(dout_vld), .empty_n(empty_n), .full_n(full_n),
        .pae_n(pae_n), .paf_n(paf_n)
    );

    // ---------------- reference model (shared clock only) ----------------
    int mq[$];
    int wh[4], rh[4];
    bit m_load, m_sel, m_e_n, m_f_n, m_pae_n, m_paf_n;
    int m_ae, m_af, m_q;

    always @(posedge clk) begin : model
        bit wf, lf, rf;
        int nw, nr, rc, wc, ae0, af0;
        if (!async_ph) begin
            if (!rst_n) begin
                m_load = !wen2_ld;
                m_sel = 0; m_ae = 7; m_af = 7; m_q = 0;
                m_e_n = 0; m_pae_n = 0; m_f_n = 1; m_paf_n = 1;
                for (int i = 0; i < 4; i++) begin wh[i] = 0; rh[i] = 0; end
                mq.delete();
            end else begin
                wf = !wen1_n && wen2_ld && m_f_n;
                lf = m_load && !wen1_n && !wen2_ld;
                rf = !ren1_n && !ren2_n && m_e_n;
                ae0 = m_ae; af0 = m_af;
                if (wf) mq.push_back(int'(din));
                if (rf) m_q = mq.pop_front();
                nw = wh[0] + int'(wf);
                nr = rh[0] + int'(rf);
                for (int i = 3; i > 0; i--) begin wh[i] = wh[i-1]; rh[i] = rh[i-1]; end
                wh[0] = nw; rh[0] = nr;
                rc = wh[3] - nr;
                wc = nw - rh[3];
                m_e_n   = (rc != 0);
                m_pae_n = !(rc <= ae0);
                m_f_n   = (wc != DEPTH);
                m_paf_n = !(wc >= DEPTH - af0);
                if (lf) begin
                    if (!m_sel) m_ae = int'(din) & 255;
                    else        m_af = int'(din) & 255;
                    m_sel = !m_sel;
                end
            end
        end
    end

    // ---------------- checking helpers ----------------
    task automatic chk(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
        chk("R5 empty_n vs model", int'(empty_n), int'(m_e_n));
        chk("R5 full_n vs model", int'(full_n), int'(m_f_n));
        chk("R6 pae_n vs model", int'(pae_n), int'(m_pae_n));
        chk("R6 paf_n vs model", int'(paf_n), int'(m_paf_n));
        chk("R3 dout vs model", int'(dout), oe_n ? 0 : m_q);
        chk("R9 dout_vld vs model", int'(dout_vld), int'(!oe_n));
    endtask

    task automatic idle();
        wen1_n = 1; wen2_ld = 1; ren1_n = 1; ren2_n = 1;
    endtask

    task automatic do_reset(input bit pin);
        rst_n = 0; idle(); wen2_ld = pin;
        repeat (4) tick();
        rst_n = 1; wen2_ld = 1;
        tick();
    endtask

    task automatic wr(input int v);
        din = 9'(v); wen1_n = 0; wen2_ld = 1; tick(); idle();
    endtask

    task automatic rd();
        ren1_n = 0; ren2_n = 0; tick(); idle();
    endtask

    function automatic int pat(input int i);
        return (i * 29 + 3) & 511;
    endfunction

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        #400000;
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog R11 actual=%0d expected=%0d", 0, 1);
            summary();
            $finish;
        end
    end

    // ---------------- stimulus ----------------
    initial begin
        rst_n = 0; din = '0; oe_n = 0; idle();
        do_reset(1'b1);

        // R10: reset state
        chk("R10 empty_n after reset", int'(empty_n), 0);
        chk("R10 full_n after reset", int'(full_n), 1);
        chk("R10 pae_n after reset", int'(pae_n), 0);
        chk("R10 paf_n after reset", int'(paf_n), 1);
        chk("R10 dout after reset", int'(dout), 0);

        // R2: incomplete enables store nothing
        din = 9'd5; wen1_n = 0; wen2_ld = 0; tick();
        wen1_n = 1; wen2_ld = 1; tick(); idle();
        repeat (4) tick();
        chk("R2 gated write ignored", int'(empty_n), 0);

        for (int i = 0; i < 10; i++) wr(pat(i));
        repeat (4) tick();
        chk("R2 qualified writes visible", int'(empty_n), 1);

        // R3: one read enable alone does not read
        ren1_n = 0; ren2_n = 1; tick(); idle();
        chk("R3 half enable no read", int'(dout), 0);
        for (int i = 0; i < 10; i++) begin
            rd();
            chk("R3 read data order", int'(dout), pat(i));
            if (i % 3 == 0) tick();
        end

        // R9: output qualifier
        oe_n = 1; tick();
        chk("R9 dout zero when disabled", int'(dout), 0);
        chk("R9 valid low when disabled", int'(dout_vld), 0);
        oe_n = 0; tick();
        chk("R9 dout restored", int'(dout), pat(9));

        // R4: underflow read ignored
        repeat (4) tick();
        rd();
        chk("R4 empty read holds dout", int'(dout), pat(9));
        wr(77); repeat (4) tick(); rd();
        chk("R4 pointer not advanced by empty read", int'(dout), 77);

        // R1/R4: fill, overflow attempt, drain
        do_reset(1'b1);
        wen1_n = 0; wen2_ld = 1;
        for (int i = 0; i < DEPTH; i++) begin din = 9'(pat(i)); tick(); end
        idle(); repeat (4) tick();
        chk("R1 full_n at DEPTH words", int'(full_n), 0);
        chk("R6 paf_n at DEPTH words", int'(paf_n), 0);
        wr(9'h155); repeat (4) tick();
        ren1_n = 0; ren2_n = 0;
        for (int i = 0; i < DEPTH; i++) begin
            tick();
            chk("R1 drain order", int'(dout), pat(i));
        end
        idle(); repeat (4) tick();
        chk("R4 overflow word dropped", int'(empty_n), 0);
        chk("R4 last word is last accepted", int'(dout), pat(DEPTH - 1));

        // R7/R8: load mode, load sequence with wrap
        do_reset(1'b0);
        din = 9'd3;  wen1_n = 0; wen2_ld = 0; tick();
        din = 9'd10; tick();
        din = 9'h114; tick();          // truncated to 20 on 8 bits
        idle(); repeat (4) tick();
        chk("R7 loads store no word", int'(empty_n), 0);
        for (int i = 0; i < 20; i++) wr(i);
        repeat (4) tick();
        chk("R8 pae_n low at 20 words (wrapped ae=20)", int'(pae_n), 0);
        wr(20); repeat (4) tick();
        chk("R8 pae_n high at 21 words", int'(pae_n), 1);
        for (int i = 21; i < 245; i++) wr(i);
        chk("R6 paf_n high at 245 words (af=10)", int'(paf_n), 1);
        wr(245);
        chk("R6 paf_n low at 246 words", int'(paf_n), 0);
        chk("R7 write in load mode accepted", int'(full_n), 1);

        // R11: unrelated clocks, streaming
        rst_n = 0; idle(); async_ph = 1;
        repeat (8) @(negedge clk);
        @(negedge clk); rst_n = 1;
        begin
            int aq[$];
            fork
                begin : writer
                    int sent = 0, cyc = 0;
                    while (sent < 300) begin
                        @(negedge clk);
                        if (full_n && ((cyc % 5) != 0)) begin
                            din = 9'(pat(sent + 7));
                            wen1_n = 0; wen2_ld = 1;
                            aq.push_back(pat(sent + 7));
                            sent++;
                        end else begin
                            wen1_n = 1;
                        end
                        cyc++;
                    end
                    @(negedge clk); wen1_n = 1;
                end
                begin : reader
                    int got = 0, cyc = 0;
                    bit pend = 0;
                    while (got < 300) begin
                        @(negedge rclk);
                        if (pend) begin
                            chk("R11 async order", int'(dout), aq.pop_front());
                            got++;
                        end
                        if (got < 300 && empty_n && ((cyc % 3) != 1)) begin
                            ren1_n = 0; ren2_n = 0; pend = 1;
                        end else begin
                            ren1_n = 1; ren2_n = 1; pend = 0;
                        end
                        cyc++;
                    end
                    ren1_n = 1; ren2_n = 1;
                end
            join
        end
        repeat (6) @(negedge rclk);
        chk("R11 drained empty", int'(empty_n), 0);

        done = 1;
        summary();
        $finish;
    end
endmodule